// File: doc/BRIEF.md
# Keypad Matrix Scanner

The scanner walks a key matrix of up to 16 rows by 16 columns. Keys are active low: the block pulls one row low at a time, waits a programmed number of clock cycles for the lines to settle, and then stores the 16 column levels as that row's data word. Software programs it through a small word-addressed register port. It sets the operating mode, the per-row settle delay, the gap between scans, and how many rows and columns take part. It then reads back the row words and a three-bit event status that drives one interrupt line through a mask.

Four modes are encoded in a 2-bit field: 0 idle, 1 any-key detect, 2 single scan, 3 continuous scan. In detect mode every row is pulled low at once and the data words are left alone. A pressed key raises the key event, and that event keeps re-asserting while the key is held. A single scan makes one pass over the enabled rows and then writes the mode back to idle by itself. Continuous scan waits out the gap after each pass and starts again. The scan state machine has five states. IDLE waits for a scan mode, and in detect mode it pulls all rows low. SETTLE drives the current row and counts the settle delay. CAPTURE stores one word. FINISH marks the end of a pass. GAP counts the inter-scan delay.

The transitions are these. IDLE goes to SETTLE when a scan mode starts and at least one row is enabled, or straight to FINISH when none is. SETTLE goes to CAPTURE when its counter equals the settle value. CAPTURE goes back to SETTLE for the next row, or to FINISH after the last enabled row. FINISH goes to GAP in continuous mode and to IDLE otherwise. GAP goes to SETTLE for row 0, or to FINISH when no row is enabled, once its counter equals the gap value. From SETTLE, CAPTURE and GAP, a mode that is no longer 2 or 3 sends the machine back to IDLE.

Top module: `kps_scanner`

Register map (word address on `bus_addr`, write data on `bus_wdata`, read data combinational on `bus_rdata`):

| Address | Contents |
|---|---|
| 0 | mode, bits 1:0 |
| 1 | settle delay, bits 13:0 |
| 2 | scan gap, bits 15:0 |
| 3 | row count, bits 7:0 |
| 4 | column count, bits 7:0 |
| 5 | status, bits 2:0 (bit 0 pass done, bit 1 data changed, bit 2 key in detect mode); writing 1 clears |
| 6 | interrupt mask, bits 2:0 |
| 16+r | row r data word, bits 15:0 |

## Requirements
- R1: After reset, the block is in the following state. Mode is 0, status is 0, mask is 0 and `irq` is 0. Settle and gap are 0, row count and column count are 16, all of `row_drive_n` is 1, and every row data word reads 16'hFFFF.
- R2: Registers sit at the addresses of the map. The mode field encodes 0 idle, 1 any-key detect, 2 single scan and 3 continuous scan.
- R3: In mode 2, the block makes one pass over the enabled rows and then sets status bit 0. Mode then reads back 0 without any software write.
- R4: In mode 3, mode stays 3 and passes repeat. Between two passes, all rows are released for exactly GAP+2 cycles, where GAP is the value at address 2.
- R5: While scanning, at most one row line is low. Each enabled row is held low for exactly SETTLE+2 cycles, where SETTLE is the value at address 1.
- R6: A captured word has bit j equal to the column j level (0 means pressed) for j below the column count, and 1 for every j at or above it. A column count above 16 acts as 16.
- R7: Rows at or above the row count keep their previous word. A row count above 16 acts as 16. A row count of 0 completes the pass (status bit 0) without changing any word.
- R8: Status bit 1 is set when a pass captures at least one word that differs from the word stored for that row, and it is not set by a pass with no difference.
- R9: In mode 1, all rows are driven low and no data word changes. Status bit 2 is set while any enabled column is low, and a clear write does not take effect while the key is held.
- R10: Writing status with a bit at 1 clears that bit once its set condition is gone. Writing a 0 bit leaves that status bit unchanged.
- R11: `irq` is 1 exactly when some status bit is 1 and its mask bit at address 6 is 1.
- R12: If software writes mode 0 during a scan, the scan stops. All rows are released within two cycles, and status bit 0 is not set by the stopped pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| col_in_n | input | 16 | Column sense lines, low means a pressed key on a driven row |
| row_drive_n | output | 16 | Row drive lines, low selects a row |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: 16 rows, 16 columns, a 14-bit settle field, a 16-bit gap field and 8-bit count fields. A behavioural key matrix sits beside the block and pulls a column low whenever a pressed key's row is driven. The bench programs short settle and gap values (1 to 40 cycles), so the SETTLE+2 and GAP+2 windows can be counted cycle by cycle. The 8-bit counts let it program 0, 2, 4, 8, 16 and 200. This reaches the empty pass, partial row and column coverage, stale rows, forced-1 columns and count saturation.

// File: rtl/kps_pkg.sv
package kps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CAPTURE,
        ST_FINISH,
        ST_GAP
    } scan_state_t;

    localparam logic [1:0] MODE_IDLE   = 2'd0;
    localparam logic [1:0] MODE_DETECT = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;
    localparam logic [1:0] MODE_CONT   = 2'd3;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_MODE   = 5'd0;
    localparam logic [ADDR_W-1:0] A_SETTLE = 5'd1;
    localparam logic [ADDR_W-1:0] A_GAP    = 5'd2;
    localparam logic [ADDR_W-1:0] A_ROWS   = 5'd3;
    localparam logic [ADDR_W-1:0] A_COLS   = 5'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd5;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'd6;

    localparam int EV_DONE = 0;
    localparam int EV_CHG  = 1;
    localparam int EV_KEY  = 2;
    localparam int EV_W    = 3;
endpackage

// File: rtl/kps_regs.sv
module kps_regs
    import kps_pkg::*;
#(
    parameter int SET_W = 14,
    parameter int GAP_W = 16,
    parameter int CFG_W = 8,
    parameter int NROW  = 16,
    parameter int NCOL  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              pass_done,
    input  logic              single_end,
    input  logic              row_changed,
    input  logic              anykey,
    output logic [1:0]        mode,
    output logic [SET_W-1:0]  settle,
    output logic [GAP_W-1:0]  gap,
    output logic [CFG_W-1:0]  rows_cfg,
    output logic [CFG_W-1:0]  cols_cfg,
    output logic [EV_W-1:0]   status,
    output logic [EV_W-1:0]   mask,
    output logic              irq
);
    logic [EV_W-1:0] ev_set;
    logic [EV_W-1:0] ev_clr;
    logic            wr_mode;

    assign wr_mode = bus_wr && (bus_addr == A_MODE);

    always_comb begin
        ev_set          = '0;
        ev_set[EV_DONE] = pass_done;
        ev_set[EV_CHG]  = row_changed;
        ev_set[EV_KEY]  = (mode == MODE_DETECT) && anykey;
        ev_clr          = (bus_wr && (bus_addr == A_STAT)) ? bus_wdata[EV_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_IDLE;
            settle   <= '0;
            gap      <= '0;
            rows_cfg <= CFG_W'(NROW);
            cols_cfg <= CFG_W'(NCOL);
            status   <= '0;
            mask     <= '0;
        end else begin
            if (wr_mode) begin
                mode <= bus_wdata[1:0];
            end else if (single_end) begin
                mode <= MODE_IDLE;
            end
            if (bus_wr && (bus_addr == A_SETTLE)) settle   <= bus_wdata[SET_W-1:0];
            if (bus_wr && (bus_addr == A_GAP))    gap      <= bus_wdata[GAP_W-1:0];
            if (bus_wr && (bus_addr == A_ROWS))   rows_cfg <= bus_wdata[CFG_W-1:0];
            if (bus_wr && (bus_addr == A_COLS))   cols_cfg <= bus_wdata[CFG_W-1:0];
            if (bus_wr && (bus_addr == A_MASK))   mask     <= bus_wdata[EV_W-1:0];
            status <= ev_set | (status & ~ev_clr);
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/kps_fsm.sv
module kps_fsm
    import kps_pkg::*;
#(
    parameter int NROW  = 16,
    parameter int SET_W = 14,
    parameter int GAP_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode,
    input  logic [SET_W-1:0]          settle,
    input  logic [GAP_W-1:0]          gap,
    input  logic [$clog2(NROW):0]     eff_rows,
    output logic [NROW-1:0]           row_drive_n,
    output logic                      cap_valid,
    output logic [$clog2(NROW)-1:0]   cap_row,
    output logic                      pass_done,
    output logic                      single_end,
    output logic                      busy
);
    localparam int RIW   = $clog2(NROW);
    localparam int CNT_W = (SET_W > GAP_W) ? SET_W : GAP_W;

    scan_state_t      state, state_n;
    logic [RIW-1:0]   row, row_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             scan_on;
    logic [RIW:0]     row_next;

    assign scan_on  = (mode == MODE_SINGLE) || (mode == MODE_CONT);
    assign row_next = {1'b0, row} + (RIW+1)'(1);

    always_comb begin
        state_n = state;
        row_n   = row;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (scan_on) begin
                    row_n   = '0;
                    cnt_n   = '0;
                    state_n = (eff_rows == '0) ? ST_FINISH : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!scan_on) begin
                    state_n = ST_IDLE;
                end else if (cnt == CNT_W'(settle)) begin
                    state_n = ST_CAPTURE;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_CAPTURE: begin
                if (!scan_on) begin
                    state_n = ST_IDLE;
                end else if (row_next >= eff_rows) begin
                    state_n = ST_FINISH;
                end else begin
                    row_n   = row_next[RIW-1:0];
                    cnt_n   = '0;
                    state_n = ST_SETTLE;
                end
            end
            ST_FINISH: begin
                cnt_n   = '0;
                state_n = (mode == MODE_CONT) ? ST_GAP : ST_IDLE;
            end
            ST_GAP: begin
                if (!scan_on) begin
                    state_n = ST_IDLE;
                end else if (cnt == CNT_W'(gap)) begin
                    row_n   = '0;
                    cnt_n   = '0;
                    state_n = (eff_rows == '0) ? ST_FINISH : ST_SETTLE;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            row   <= '0;
            cnt   <= '0;
        end else begin
            state <= state_n;
            row   <= row_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        row_drive_n = '1;
        cap_valid   = 1'b0;
        pass_done   = 1'b0;
        single_end  = 1'b0;
        busy        = (state != ST_IDLE);
        cap_row     = row;
        unique case (state)
            ST_IDLE: begin
                if (mode == MODE_DETECT) row_drive_n = '0;
            end
            ST_SETTLE: begin
                row_drive_n[row] = 1'b0;
            end
            ST_CAPTURE: begin
                row_drive_n[row] = 1'b0;
                cap_valid        = scan_on;
            end
            ST_FINISH: begin
                pass_done  = 1'b1;
                single_end = (mode == MODE_SINGLE);
            end
            ST_GAP: begin
                row_drive_n = '1;
            end
            default: row_drive_n = '1;
        endcase
    end
endmodule

// File: rtl/kps_rowbank.sv
module kps_rowbank #(
    parameter int NROW = 16,
    parameter int NCOL = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_valid,
    input  logic [$clog2(NROW)-1:0] cap_row,
    input  logic [NCOL-1:0]         col_in_n,
    input  logic [NCOL-1:0]         col_keep,
    output logic [NCOL-1:0]         row_data [NROW],
    output logic                    row_changed
);
    logic [NCOL-1:0] word;

    assign word        = col_in_n | ~col_keep;
    assign row_changed = cap_valid && (word != row_data[cap_row]);

    for (genvar r = 0; r < NROW; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_data[r] <= '1;
            end else if (cap_valid && (cap_row == r[$clog2(NROW)-1:0])) begin
                row_data[r] <= word;
            end
        end
    end
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner
    import kps_pkg::*;
#(
    parameter int NROW  = 16,
    parameter int NCOL  = 16,
    parameter int SET_W = 14,
    parameter int GAP_W = 16,
    parameter int CFG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCOL-1:0]   col_in_n,
    output logic [NROW-1:0]   row_drive_n,
    output logic              irq
);
    localparam int RIW = $clog2(NROW);

    logic [1:0]       mode;
    logic [SET_W-1:0] settle;
    logic [GAP_W-1:0] gap;
    logic [CFG_W-1:0] rows_cfg, cols_cfg;
    logic [EV_W-1:0]  status, mask;
    logic [RIW:0]     eff_rows;
    logic [NCOL-1:0]  col_keep;
    logic [NCOL-1:0]  row_data [NROW];
    logic             cap_valid, pass_done, single_end, busy, row_changed, anykey;
    logic [RIW-1:0]   cap_row;

    assign eff_rows = (rows_cfg > CFG_W'(NROW)) ? (RIW+1)'(NROW) : (RIW+1)'(rows_cfg);

    for (genvar j = 0; j < NCOL; j++) begin : g_col
        assign col_keep[j] = (CFG_W'(j) < cols_cfg);
    end

    assign anykey = |(~col_in_n & col_keep);

    kps_regs #(.SET_W(SET_W), .GAP_W(GAP_W), .CFG_W(CFG_W), .NROW(NROW), .NCOL(NCOL)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pass_done(pass_done), .single_end(single_end), .row_changed(row_changed), .anykey(anykey),
        .mode(mode), .settle(settle), .gap(gap), .rows_cfg(rows_cfg), .cols_cfg(cols_cfg),
        .status(status), .mask(mask), .irq(irq)
    );

    kps_fsm #(.NROW(NROW), .SET_W(SET_W), .GAP_W(GAP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .settle(settle), .gap(gap), .eff_rows(eff_rows),
        .row_drive_n(row_drive_n), .cap_valid(cap_valid), .cap_row(cap_row),
        .pass_done(pass_done), .single_end(single_end), .busy(busy)
    );

    kps_rowbank #(.NROW(NROW), .NCOL(NCOL)) u_bank (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_row(cap_row),
        .col_in_n(col_in_n), .col_keep(col_keep), .row_data(row_data), .row_changed(row_changed)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata[NCOL-1:0] = row_data[bus_addr[RIW-1:0]];
        end else begin
            case (bus_addr)
                A_MODE:   bus_rdata[1:0]       = mode;
                A_SETTLE: bus_rdata[SET_W-1:0] = settle;
                A_GAP:    bus_rdata[GAP_W-1:0] = gap;
                A_ROWS:   bus_rdata[CFG_W-1:0] = rows_cfg;
                A_COLS:   bus_rdata[CFG_W-1:0] = cols_cfg;
                A_STAT:   bus_rdata[EV_W-1:0]  = status;
                A_MASK:   bus_rdata[EV_W-1:0]  = mask;
                default:  bus_rdata            = '0;
            endcase
        end
    end
endmodule

// File: rtl/kps_checker.sv
module kps_checker
    import kps_pkg::*;
#(
    parameter int NROW = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [NROW-1:0]         row_drive_n,
    input logic                    irq,
    input logic [1:0]              mode,
    input logic [EV_W-1:0]         status,
    input logic [EV_W-1:0]         mask,
    input logic                    busy,
    input logic                    cap_valid,
    input logic [$clog2(NROW)-1:0] cap_row,
    input logic [$clog2(NROW):0]   eff_rows,
    input logic                    single_end,
    input logic                    anykey
);
    p_one_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot0(~row_drive_n));

    p_row_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> ({1'b0, cap_row} < eff_rows));

    p_single_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (single_end && !(bus_wr && bus_addr == A_MODE)) |=> (mode == MODE_IDLE));

    p_key_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DETECT && anykey) |=> status[EV_KEY]);

    p_detect_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DETECT && !busy) |-> (row_drive_n == '0));

    p_w1c_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[EV_DONE] && !(bus_wr && bus_addr == A_STAT && bus_wdata[EV_DONE])) |=> status[EV_DONE]);

    p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && !busy) |-> (&row_drive_n));
endmodule

bind kps_scanner kps_checker #(.NROW(NROW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .row_drive_n(row_drive_n), .irq(irq), .mode(mode), .status(status), .mask(mask),
    .busy(busy), .cap_valid(cap_valid), .cap_row(cap_row), .eff_rows(eff_rows),
    .single_end(single_end), .anykey(anykey)
);

// File: tb/sim_kps_scanner.sv
module sim_kps_scanner;
    import kps_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] col_in_n;
    logic [15:0] row_drive_n;
    logic        irq;

    logic [15:0][15:0] keys = '0;
    logic [15:0]       exp_rows [16];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    kps_scanner u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .col_in_n(col_in_n), .row_drive_n(row_drive_n), .irq(irq)
    );

    always_comb begin
        for (int j = 0; j < 16; j++) begin
            col_in_n[j] = 1'b1;
            for (int r = 0; r < 16; r++) begin
                if (keys[r][j] && !row_drive_n[r]) col_in_n[j] = 1'b0;
            end
        end
    end

    // rows[31:24] cols[23:16] key_row[15:12] key_col[11:8] key_on[4] changed[0]
    localparam logic [31:0] VECS [8] = '{
        32'h1010_3511, 32'h1010_3510, 32'h0210_7110, 32'h0804_7111,
        32'h1004_2911, 32'h0010_0010, 32'hC8C8_FF11, 32'h1010_0001
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(A_STAT, v);
            if (v[EV_DONE]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic model_scan(input int rows, input int cols);
        int er;
        logic [15:0] w;
        er = (rows > 16) ? 16 : rows;
        for (int r = 0; r < er; r++) begin
            for (int j = 0; j < 16; j++) w[j] = (j < cols) ? ~keys[r][j] : 1'b1;
            exp_rows[r] = w;
        end
    endtask

    task automatic check_rows(input string tag);
        logic [31:0] v;
        for (int r = 0; r < 16; r++) begin
            rd(5'(16 + r), v);
            chk(v[15:0] == exp_rows[r], tag, v, {16'h0, exp_rows[r]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int cnt;
        bit extra;
        for (int r = 0; r < 16; r++) exp_rows[r] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_MODE, v); chk(v == 0, "R1 mode", v, 0);
        rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
        rd(A_ROWS, v); chk(v == 16, "R1 rows", v, 16);
        rd(A_COLS, v); chk(v == 16, "R1 cols", v, 16);
        chk(irq == 1'b0, "R1 irq", {31'h0, irq}, 0);
        chk(row_drive_n == 16'hFFFF, "R1 row drive", {16'h0, row_drive_n}, 32'hFFFF);
        check_rows("R1 data");

        // R2 register addresses
        wr(A_SETTLE, 32'd2);
        rd(A_SETTLE, v); chk(v == 2, "R2 settle reg", v, 2);
        wr(A_GAP, 32'd0);

        // table walk: R3 R6 R7 R8
        foreach (VECS[i]) begin
            int rows, cols;
            rows = int'(VECS[i][31:24]);
            cols = int'(VECS[i][23:16]);
            keys = '0;
            if (VECS[i][4]) keys[VECS[i][15:12]][VECS[i][11:8]] = 1'b1;
            wr(A_ROWS, rows);
            wr(A_COLS, cols);
            wr(A_STAT, 32'h7);
            wr(A_MODE, {30'h0, MODE_SINGLE});
            wait_done(ok);
            chk(ok, "R3 pass done", {31'h0, ok}, 1);
            @(negedge clk);
            rd(A_MODE, v); chk(v == 0, "R3 mode back to idle", v, 0);
            rd(A_STAT, v);
            chk(v[EV_CHG] == VECS[i][0], "R8 changed flag", v, {31'h0, VECS[i][0]});
            model_scan(rows, cols);
            check_rows("R6 R7 row data");
        end

        // R10 write 0 keeps, write 1 clears (status now 3)
        rd(A_STAT, v); chk(v == 3, "R10 status before", v, 3);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk(v == 3, "R10 zero write keeps", v, 3);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk(v == 2, "R10 one write clears", v, 2);
        wr(A_STAT, 32'h7);

        // R9 any-key detect, R11 mask
        keys = '0;
        wr(A_ROWS, 16); wr(A_COLS, 16);
        wr(A_MODE, {30'h0, MODE_DETECT});
        chk(row_drive_n == 16'h0000, "R9 all rows low", {16'h0, row_drive_n}, 0);
        rd(A_STAT, v); chk(v == 0, "R9 no key no event", v, 0);
        keys[5][2] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_STAT, v); chk(v[EV_KEY] == 1'b1, "R9 key event", v, 4);
        chk(irq == 1'b0, "R11 masked off", {31'h0, irq}, 0);
        wr(A_MASK, 32'h4);
        chk(irq == 1'b1, "R11 mask on", {31'h0, irq}, 1);
        wr(A_MASK, 32'h3);
        chk(irq == 1'b0, "R11 other bits masked", {31'h0, irq}, 0);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v); chk(v[EV_KEY] == 1'b1, "R9 clear ignored while held", v, 4);
        keys = '0;
        repeat (2) @(negedge clk);
        rd(A_STAT, v); chk(v[EV_KEY] == 1'b1, "R10 sticky after release", v, 4);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v); chk(v[EV_KEY] == 1'b0, "R10 cleared after release", v, 0);
        check_rows("R9 data untouched");
        wr(A_MODE, {30'h0, MODE_IDLE});
        wr(A_MASK, 32'h0);

        // R5 settle window
        wr(A_SETTLE, 32'd3); wr(A_ROWS, 1); wr(A_STAT, 32'h7);
        wr(A_MODE, {30'h0, MODE_SINGLE});
        cnt = 0; extra = 1'b0; ok = 1'b0;
        for (int i = 0; i < 200 && !ok; i++) begin
            if (!row_drive_n[0]) cnt++;
            if (row_drive_n[15:1] != 15'h7FFF) extra = 1'b1;
            rd(A_STAT, v);
            ok = v[EV_DONE];
            @(negedge clk);
        end
        chk(cnt == 5, "R5 row low cycles", cnt, 5);
        chk(!extra, "R5 other rows idle", {31'h0, extra}, 0);

        // R4 continuous gap
        wr(A_SETTLE, 32'd1); wr(A_GAP, 32'd6);
        wr(A_MODE, {30'h0, MODE_CONT});
        for (int i = 0; i < 100 && row_drive_n[0]; i++) @(negedge clk);
        for (int i = 0; i < 100 && !row_drive_n[0]; i++) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 100 && row_drive_n[0]; i++) begin cnt++; @(negedge clk); end
        chk(cnt == 8, "R4 gap release cycles", cnt, 8);
        rd(A_MODE, v); chk(v == 3, "R4 mode stays continuous", v, 3);
        wr(A_STAT, 32'h7);
        wait_done(ok);
        chk(ok, "R4 pass repeats", {31'h0, ok}, 1);
        wr(A_MODE, {30'h0, MODE_IDLE});

        // R12 abort mid-scan
        wr(A_SETTLE, 32'd40); wr(A_ROWS, 16);
        wr(A_MODE, {30'h0, MODE_SINGLE});
        repeat (20) @(negedge clk);
        wr(A_STAT, 32'h7);
        wr(A_MODE, {30'h0, MODE_IDLE});
        @(negedge clk);
        chk(row_drive_n == 16'hFFFF, "R12 rows released", {16'h0, row_drive_n}, 32'hFFFF);
        repeat (100) @(negedge clk);
        rd(A_STAT, v); chk(v[EV_DONE] == 1'b0, "R12 no completion", v, 0);
        rd(A_MODE, v); chk(v == 0, "R12 mode idle", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule